// File: doc/BRIEF.md
# Accumulating Conversion Sequencer

This block paces a series of sample captures on a slow converter clock and sums them into a single 16-bit result. Software sets up and starts each run through a byte-wide register bus. During a run the block divides the system clock by a power of two to form the converter clock. Every 15 converter clocks it captures one 12-bit value from an external sample port. After the chosen number of captures, it writes the saturated sum to two result bytes, raises a ready flag and, if that flag is enabled, asserts an interrupt request.

A run either stops after its result or starts again at once. One input-select code swaps the summed result for a 16-bit pre-computed temperature word taken from a second input port. Software can start a new run while one is pending, which abandons the pending run. It can also abort a run by clearing the enable bit.

Top module: `adc_accum_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and irq is low.
- R2: The enable/mode register (0x00), count register (0x01), divider register (0x02), input select (0x08) and interrupt enable (0x0C) read back the full byte last written. Addresses with no register read 0x00.
- R3: Writing a byte with bit 0 set to the command register (0x0A) starts a run only while bit 0 of 0x00 is 1, and is ignored otherwise. Command bit 0 reads 1 from the start until the run completes, and 0 afterwards.
- R4: With divider code P = bits [2:0] of 0x02 and count code C = bits [2:0] of 0x01, both taken when the run starts, a run lasts 15 × N × D system clocks. D = 2^(P+1). N = 2^C, and codes 6 and 7 both give N = 64. The flag is visible in the cycle after the run's last clock edge.
- R5: sample_strobe is high in the last system clock of each 15-converter-clock slot, and sample_data is captured on the edge that ends that cycle. The result is the sum of the captured values: low byte at 0x10, high byte at 0x11.
- R6: The sum saturates at 0xFFFF and never wraps.
- R7: When input select equals 0x42 at completion, the result is loaded from temp_data instead of the sum.
- R8: Completion sets bit 0 of 0x0D. irq is high exactly while that bit and bit 0 of 0x0C are both 1.
- R9: Writing 1 to bit 0 of 0x0D clears the flag. Writing 0 leaves it unchanged. A completion on the same edge as the clear leaves the flag set.
- R10: Bus writes to 0x10 and 0x11 do not change the result.
- R11: A start write while a run is pending abandons that run without a result, and timing restarts from zero at the write.
- R12: If bit 1 of 0x00 is set at completion, a new run begins on the completion edge with the command bit left at 0.
- R13: Writing 0x00 with bit 0 clear aborts a pending run without changing the result or the flag. An abort on the same edge as a start write or a completion wins over both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sample_data | input | 12 | Sample value captured at the end of each slot |
| temp_data | input | 16 | Pre-computed temperature result |
| sample_strobe | output | 1 | High in the cycle whose closing edge captures a sample |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- an abort always drops the busy state;
- a launch always clears the counters and the sum;
- the sum never decreases while a run adds samples;
- the result changes only on a completion;
- a completion always raises the flag;
- the command bit holds until a completion or an abort.

Only the bench scenarios can show the things that need a reference count or value:
- the exact latency for each divider and count setting;
- the summed and saturated values;
- the temperature substitution;
- that a restart rearms the timing from zero;
- that free-running mode starts the next run with no gap.

// File: rtl/adc_accum_pkg.sv
package adc_accum_pkg;
    localparam int REG_ADDR_W   = 5;
    localparam int REG_DATA_W   = 8;
    localparam int RESULT_W     = 16;

    localparam logic [REG_ADDR_W-1:0] ADR_MODE   = 5'h00;
    localparam logic [REG_ADDR_W-1:0] ADR_COUNT  = 5'h01;
    localparam logic [REG_ADDR_W-1:0] ADR_DIVIDE = 5'h02;
    localparam logic [REG_ADDR_W-1:0] ADR_INSEL  = 5'h08;
    localparam logic [REG_ADDR_W-1:0] ADR_CMD    = 5'h0A;
    localparam logic [REG_ADDR_W-1:0] ADR_IEN    = 5'h0C;
    localparam logic [REG_ADDR_W-1:0] ADR_IFLAG  = 5'h0D;
    localparam logic [REG_ADDR_W-1:0] ADR_RES_LO = 5'h10;
    localparam logic [REG_ADDR_W-1:0] ADR_RES_HI = 5'h11;

    localparam logic [REG_DATA_W-1:0] SEL_TEMPERATURE = 8'h42;

    typedef struct packed {
        logic [REG_DATA_W-1:0] mode;
        logic [REG_DATA_W-1:0] count;
        logic [REG_DATA_W-1:0] divide;
        logic [REG_DATA_W-1:0] insel;
        logic [REG_DATA_W-1:0] ien;
        logic                  flag;
        logic                  cmd;
        logic [RESULT_W-1:0]   result;
    } ctrl_regs_t;
endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int SLOT_CLKS      = 15,
    parameter int PRESC_CODE_W   = 3,
    parameter int COUNT_CODE_W   = 3,
    parameter int MAX_COUNT_CODE = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic                    halt,
    input  logic [PRESC_CODE_W-1:0] presc_code,
    input  logic [COUNT_CODE_W-1:0] count_code,
    output logic                    busy,
    output logic                    sample_tick,
    output logic                    last_sample
);
    localparam int PCNT_W = 2 ** PRESC_CODE_W;
    localparam int SLOT_W = $clog2(SLOT_CLKS);
    localparam int SAMP_W = MAX_COUNT_CODE + 1;

    typedef struct packed {
        logic                    busy;
        logic [PRESC_CODE_W-1:0] pcode;
        logic [COUNT_CODE_W-1:0] ccode;
        logic [PCNT_W-1:0]       pcnt;
        logic [SLOT_W-1:0]       slot;
        logic [SAMP_W-1:0]       samp;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    logic [PCNT_W:0]         div_full;
    logic [PCNT_W-1:0]       div_m1;
    logic [COUNT_CODE_W-1:0] eff_code;
    logic [SAMP_W:0]         nsamp;
    logic [SAMP_W-1:0]       nsamp_m1;
    logic                    tick;
    logic                    slot_end;
    logic                    last;

    always_comb begin
        div_full = (PCNT_W + 1)'(2) << tmr_q.pcode;
        div_m1   = PCNT_W'(div_full - 1'b1);
        eff_code = (int'(tmr_q.ccode) > MAX_COUNT_CODE) ? COUNT_CODE_W'(MAX_COUNT_CODE)
                                                        : tmr_q.ccode;
        nsamp    = (SAMP_W + 1)'(1) << eff_code;
        nsamp_m1 = SAMP_W'(nsamp - 1'b1);
        tick     = tmr_q.busy && (tmr_q.pcnt == div_m1);
        slot_end = tick && (tmr_q.slot == SLOT_W'(SLOT_CLKS - 1));
        last     = slot_end && (tmr_q.samp == nsamp_m1);

        tmr_d = tmr_q;
        if (halt) begin
            tmr_d.busy = 1'b0;
            tmr_d.pcnt = '0;
            tmr_d.slot = '0;
            tmr_d.samp = '0;
        end else if (launch) begin
            tmr_d.busy  = 1'b1;
            tmr_d.pcode = presc_code;
            tmr_d.ccode = count_code;
            tmr_d.pcnt  = '0;
            tmr_d.slot  = '0;
            tmr_d.samp  = '0;
        end else if (tmr_q.busy) begin
            if (tick) begin
                tmr_d.pcnt = '0;
                if (slot_end) begin
                    tmr_d.slot = '0;
                    if (last) begin
                        tmr_d.busy = 1'b0;
                        tmr_d.samp = '0;
                    end else begin
                        tmr_d.samp = tmr_q.samp + 1'b1;
                    end
                end else begin
                    tmr_d.slot = tmr_q.slot + 1'b1;
                end
            end else begin
                tmr_d.pcnt = tmr_q.pcnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy        = tmr_q.busy;
    assign sample_tick = slot_end;
    assign last_sample = last;

    assert_halt_stops_R13: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !tmr_q.busy) else $error("halt did not stop the run");

    assert_launch_rearms_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && !halt) |=> (tmr_q.busy && tmr_q.pcnt == '0 && tmr_q.slot == '0 && tmr_q.samp == '0))
        else $error("launch did not rearm timing");
endmodule

// File: rtl/adc_sat_accum.sv
module adc_sat_accum #(
    parameter int SAMPLE_W = 12,
    parameter int RES_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                add,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [RES_W-1:0]    sum_next,
    output logic [RES_W-1:0]    sum
);
    logic [RES_W-1:0] sum_d, sum_q;
    logic [RES_W:0]   wide;

    always_comb begin
        wide     = {1'b0, sum_q} + {{(RES_W + 1 - SAMPLE_W){1'b0}}, sample};
        sum_next = wide[RES_W] ? {RES_W{1'b1}} : wide[RES_W-1:0];
        sum_d    = sum_q;
        if (clear)    sum_d = '0;
        else if (add) sum_d = sum_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= '0;
        else        sum_q <= sum_d;
    end

    assign sum = sum_q;

    assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (sum_q == '0)) else $error("sum not cleared at launch");

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (add && !clear) |=> (sum_q >= $past(sum_q))) else $error("sum wrapped");
endmodule

// File: rtl/adc_accum_ctrl.sv
module adc_accum_ctrl
    import adc_accum_pkg::*;
#(
    parameter int SAMPLE_W  = 12,
    parameter int SLOT_CLKS = 15
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_we,
    input  logic [REG_DATA_W-1:0] bus_wdata,
    output logic [REG_DATA_W-1:0] bus_rdata,
    input  logic [SAMPLE_W-1:0]   sample_data,
    input  logic [RESULT_W-1:0]   temp_data,
    output logic                  sample_strobe,
    output logic                  irq
);
    localparam int PRESC_CODE_W   = 3;
    localparam int COUNT_CODE_W   = 3;
    localparam int MAX_COUNT_CODE = 6;

    ctrl_regs_t regs_d, regs_q;

    logic                busy;
    logic                tick;
    logic                last;
    logic                abort_wr;
    logic                start_wr;
    logic                clear_wr;
    logic                complete;
    logic                relaunch;
    logic                launch;
    logic [RESULT_W-1:0] sum_next;
    logic [RESULT_W-1:0] sum_now;

    adc_conv_timer #(
        .SLOT_CLKS     (SLOT_CLKS),
        .PRESC_CODE_W  (PRESC_CODE_W),
        .COUNT_CODE_W  (COUNT_CODE_W),
        .MAX_COUNT_CODE(MAX_COUNT_CODE)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch     (launch),
        .halt       (abort_wr),
        .presc_code (regs_q.divide[PRESC_CODE_W-1:0]),
        .count_code (regs_q.count[COUNT_CODE_W-1:0]),
        .busy       (busy),
        .sample_tick(tick),
        .last_sample(last)
    );

    adc_sat_accum #(
        .SAMPLE_W(SAMPLE_W),
        .RES_W   (RESULT_W)
    ) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (launch),
        .add     (tick),
        .sample  (sample_data),
        .sum_next(sum_next),
        .sum     (sum_now)
    );

    always_comb begin
        abort_wr = bus_we && (bus_addr == ADR_MODE) && !bus_wdata[0];
        start_wr = bus_we && (bus_addr == ADR_CMD) && bus_wdata[0] && regs_q.mode[0];
        clear_wr = bus_we && (bus_addr == ADR_IFLAG) && bus_wdata[0];
        complete = last && !abort_wr && !start_wr;
        relaunch = complete && regs_q.mode[1] && regs_q.mode[0];
        launch   = start_wr || relaunch;

        regs_d = regs_q;
        if (bus_we) begin
            unique case (bus_addr)
                ADR_MODE:   regs_d.mode   = bus_wdata;
                ADR_COUNT:  regs_d.count  = bus_wdata;
                ADR_DIVIDE: regs_d.divide = bus_wdata;
                ADR_INSEL:  regs_d.insel  = bus_wdata;
                ADR_IEN:    regs_d.ien    = bus_wdata;
                default: ;
            endcase
        end

        if (abort_wr)      regs_d.cmd = 1'b0;
        else if (start_wr) regs_d.cmd = 1'b1;
        else if (complete) regs_d.cmd = 1'b0;

        if (complete) begin
            regs_d.result = (regs_q.insel == SEL_TEMPERATURE) ? temp_data : sum_next;
        end

        regs_d.flag = (regs_q.flag && !clear_wr) || complete;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        unique case (bus_addr)
            ADR_MODE:   bus_rdata = regs_q.mode;
            ADR_COUNT:  bus_rdata = regs_q.count;
            ADR_DIVIDE: bus_rdata = regs_q.divide;
            ADR_INSEL:  bus_rdata = regs_q.insel;
            ADR_CMD:    bus_rdata = {{(REG_DATA_W-1){1'b0}}, regs_q.cmd};
            ADR_IEN:    bus_rdata = regs_q.ien;
            ADR_IFLAG:  bus_rdata = {{(REG_DATA_W-1){1'b0}}, regs_q.flag};
            ADR_RES_LO: bus_rdata = regs_q.result[REG_DATA_W-1:0];
            ADR_RES_HI: bus_rdata = regs_q.result[RESULT_W-1:REG_DATA_W];
            default:    bus_rdata = '0;
        endcase
    end

    assign sample_strobe = tick;
    assign irq           = regs_q.flag && regs_q.ien[0];

    assert_flag_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        complete |=> regs_q.flag) else $error("flag not set at completion");

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !complete |=> $stable(regs_q.result)) else $error("result changed without completion");

    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.cmd && !complete && !abort_wr) |=> regs_q.cmd) else $error("command bit dropped early");

    assert_cmd_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.mode[0] |-> !regs_q.cmd) else $error("command bit set while disabled");

    assert_busy_matches_cmd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.cmd |-> busy) else $error("command bit set with no run pending");
endmodule

// File: tb/adc_accum_ctrl_bench.sv
`timescale 1ns/1ps
module adc_accum_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [11:0] sample_data = '0;
    logic [15:0] temp_data = '0;
    logic        sample_strobe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_accum_ctrl u_adc_accum_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_data(sample_data),
        .temp_data(temp_data), .sample_strobe(sample_strobe), .irq(irq)
    );

    // behavioural reference: one elapsed-clock counter per run
    int m_mode, m_count, m_div, m_insel, m_ien, m_flag, m_cmd, m_res;
    int m_busy, m_cnt, m_acc, m_D, m_N;

    function automatic int m_read(int a);
        case (a)
            'h00: return m_mode;
            'h01: return m_count;
            'h02: return m_div;
            'h08: return m_insel;
            'h0A: return m_cmd;
            'h0C: return m_ien;
            'h0D: return m_flag;
            'h10: return m_res % 256;
            'h11: return m_res / 256;
            default: return 0;
        endcase
    endfunction

    function automatic int m_strobe();
        return (m_busy != 0 && ((m_cnt + 1) % (15 * m_D)) == 0) ? 1 : 0;
    endfunction

    function automatic string tag_of(int a);
        case (a)
            'h0A: return "R3";
            'h0D: return "R8";
            'h10, 'h11: return "R5";
            default: return "R2";
        endcase
    endfunction

    task automatic m_launch();
        int c;
        c = m_count % 8;
        if (c > 6) c = 6;
        m_D = 2 << (m_div % 8);
        m_N = 1 << c;
        m_busy = 1; m_cnt = 0; m_acc = 0;
    endtask

    always @(posedge clk or negedge rst_n) begin : model
        int stb, done, abort_w, start_w, clr_w;
        if (!rst_n) begin
            m_mode = 0; m_count = 0; m_div = 0; m_insel = 0; m_ien = 0;
            m_flag = 0; m_cmd = 0; m_res = 0; m_busy = 0; m_cnt = 0;
            m_acc = 0; m_D = 2; m_N = 1;
        end else begin
            stb     = m_strobe();
            done    = (stb != 0 && m_cnt + 1 == 15 * m_D * m_N) ? 1 : 0;
            abort_w = (bus_we && bus_addr == 5'h00 && !bus_wdata[0]) ? 1 : 0;
            start_w = (bus_we && bus_addr == 5'h0A && bus_wdata[0] && (m_mode % 2) == 1) ? 1 : 0;
            clr_w   = (bus_we && bus_addr == 5'h0D && bus_wdata[0]) ? 1 : 0;
            if (stb != 0) begin
                m_acc = m_acc + int'(sample_data);
                if (m_acc > 65535) m_acc = 65535;
            end
            if (abort_w != 0) begin
                m_busy = 0; m_cmd = 0; done = 0;
            end else if (start_w != 0) begin
                m_launch(); m_cmd = 1; done = 0;
            end else if (done != 0) begin
                m_res = (m_insel == 'h42) ? int'(temp_data) : m_acc;
                m_cmd = 0; m_busy = 0;
                if ((m_mode % 4) == 3) m_launch();
            end else if (m_busy != 0) begin
                m_cnt = m_cnt + 1;
            end
            m_flag = ((m_flag != 0 && clr_w == 0) || done != 0) ? 1 : 0;
            if (bus_we) begin
                case (bus_addr)
                    5'h00: m_mode  = int'(bus_wdata);
                    5'h01: m_count = int'(bus_wdata);
                    5'h02: m_div   = int'(bus_wdata);
                    5'h08: m_insel = int'(bus_wdata);
                    5'h0C: m_ien   = int'(bus_wdata);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(int'(bus_rdata) == m_read(int'(bus_addr)), tag_of(int'(bus_addr)),
                int'(bus_rdata), m_read(int'(bus_addr)));
            chk(int'(irq) == ((m_flag != 0 && (m_ien % 2) == 1) ? 1 : 0), "R8",
                int'(irq), (m_flag != 0 && (m_ien % 2) == 1) ? 1 : 0);
            chk(int'(sample_strobe) == m_strobe(), "R5", int'(sample_strobe), m_strobe());
        end
    end

    task automatic wr(logic [4:0] a, logic [7:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(logic [4:0] a, int exp, string req);
        bus_addr = a;
        #0.5;
        chk(int'(bus_rdata) == exp, req, int'(bus_rdata), exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // counts edges after a start write until the flag reads 1
    task automatic measure(output int n);
        bus_addr = 5'h0D;
        n = 0;
        while (n < 5000) begin
            @(posedge clk); n++; #1;
            if (bus_rdata[0]) break;
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            summary();
            $finish;
        end
    end

    initial begin : main
        int lat;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(1);
        // R1 reset state
        rd_chk(5'h00, 0, "R1"); rd_chk(5'h0A, 0, "R1"); rd_chk(5'h0D, 0, "R1");
        rd_chk(5'h10, 0, "R1"); rd_chk(5'h11, 0, "R1");
        chk(irq == 1'b0, "R1", int'(irq), 0);

        // R2 readback and unmapped address
        wr(5'h01, 8'hF3); wr(5'h02, 8'hA8); wr(5'h08, 8'h17);
        rd_chk(5'h01, 'hF3, "R2"); rd_chk(5'h02, 'hA8, "R2"); rd_chk(5'h08, 'h17, "R2");
        rd_chk(5'h05, 0, "R2");
        wr(5'h01, 8'h00); wr(5'h02, 8'h00); wr(5'h08, 8'h00);

        // R3 start ignored while disabled
        sample_data = 12'h123;
        wr(5'h0A, 8'h01);
        rd_chk(5'h0A, 0, "R3");
        idle(40);
        rd_chk(5'h0D, 0, "R3");

        // R3 R4 R5 single sample, divide by 2
        wr(5'h00, 8'h01);
        wr(5'h0A, 8'h01);
        rd_chk(5'h0A, 1, "R3");
        measure(lat);
        chk(lat == 30, "R4", lat, 30);
        rd_chk(5'h10, 'h23, "R5"); rd_chk(5'h11, 'h01, "R5");
        rd_chk(5'h0A, 0, "R3");

        // R8 R9 interrupt and flag clearing
        wr(5'h0C, 8'h01);
        chk(irq == 1'b1, "R8", int'(irq), 1);
        wr(5'h0D, 8'h00);
        rd_chk(5'h0D, 1, "R9");
        wr(5'h0D, 8'h01);
        rd_chk(5'h0D, 0, "R9");
        chk(irq == 1'b0, "R8", int'(irq), 0);

        // R10 result bytes are not writable
        wr(5'h10, 8'hFF); wr(5'h11, 8'hFF);
        rd_chk(5'h10, 'h23, "R10"); rd_chk(5'h11, 'h01, "R10");

        // R4 R5 eight samples, divide by 4
        wr(5'h02, 8'h01); wr(5'h01, 8'h03);
        sample_data = 12'hABC;
        wr(5'h0A, 8'h01);
        measure(lat);
        chk(lat == 480, "R4", lat, 480);
        rd_chk(5'h10, 'hE0, "R5"); rd_chk(5'h11, 'h55, "R5");
        wr(5'h0D, 8'h01);

        // R6 saturation with 32 full-scale samples
        wr(5'h02, 8'h00); wr(5'h01, 8'h05);
        sample_data = 12'hFFF;
        wr(5'h0A, 8'h01);
        measure(lat);
        chk(lat == 960, "R4", lat, 960);
        rd_chk(5'h10, 'hFF, "R6"); rd_chk(5'h11, 'hFF, "R6");
        wr(5'h0D, 8'h01);

        // R7 temperature substitution
        wr(5'h01, 8'h00); wr(5'h08, 8'h42);
        temp_data = 16'hBEEF;
        wr(5'h0A, 8'h01);
        measure(lat);
        rd_chk(5'h10, 'hEF, "R7"); rd_chk(5'h11, 'hBE, "R7");
        wr(5'h08, 8'h00); wr(5'h0D, 8'h01);

        // R11 restart while pending
        sample_data = 12'h055;
        wr(5'h0A, 8'h01);
        idle(18);
        wr(5'h0A, 8'h01);
        measure(lat);
        chk(lat == 30, "R11", lat, 30);
        rd_chk(5'h10, 'h55, "R11");
        wr(5'h0D, 8'h01);

        // R13 abort by clearing enable
        sample_data = 12'h777;
        wr(5'h0A, 8'h01);
        idle(10);
        wr(5'h00, 8'h00);
        idle(60);
        rd_chk(5'h0D, 0, "R13"); rd_chk(5'h0A, 0, "R13");
        rd_chk(5'h10, 'h55, "R13"); rd_chk(5'h11, 'h00, "R13");

        // R12 free-running restart with no gap
        wr(5'h00, 8'h03);
        sample_data = 12'h111;
        wr(5'h0A, 8'h01);
        bus_addr = 5'h10;
        lat = 0;
        while (lat < 200) begin
            @(posedge clk); lat++; #1;
            if (lat == 30) begin
                rd_chk(5'h0A, 0, "R12");
                sample_data = 12'h222;
                bus_addr = 5'h10;
                #0.5;
            end
            if (bus_rdata == 8'h22) break;
        end
        chk(lat == 60, "R12", lat, 60);
        wr(5'h00, 8'h00);
        idle(5);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule